// File: doc/BRIEF.md
# Asynchronous Bus Read-Cycle Sequencer

This block runs one read transfer on an asynchronous external bus for a processor core. Its clock runs at twice the bus rate, so every clock tick is one half-clock bus state. The read moves through eight named states, S1 to S8. The core gives a start pulse, an address and two byte-select bits. The block then drives a cycle-start marker, an address strobe and three data strobes, all active low. It waits until the external device either acknowledges the transfer or reports a bus error.

Wait states come only in whole bus clocks, which means pairs of half-states. The block checks for termination when leaving S4 and again at the end of each wait pair. The acknowledge and bus-error inputs come from outside the clock domain, so a two-flop synchronizer sits in front of them. The cycle takes one of two paths. An acknowledge, with or without a bus error, ends the cycle at S7 and captures the read data. A bus error without acknowledge runs through S8 and reports an error with no data. One request that arrives while a cycle is under way is held and started once the bus is idle again.

Top module: `async_rd_sequencer`

## Requirements
- R1: `bus_start_n` goes low for exactly one clock, the S1 state that opens a cycle. It stays high at every other time.
- R2: The clock after S1 (state S2), `bus_as_n` goes low. It stays low through S3, S4, every wait state, S5 and S6.
- R3: `bus_ack_n` and `bus_berr_n` are used only after two synchronizing flops. A termination driven low in the same half-clock that the strobes are first seen low still gives the shortest cycle: `core_done` comes 6 clocks after S1.
- R4: Wait states are added two at a time. With the acknowledge first driven low d half-clocks after the strobes are first seen low, `core_done` comes 6 + 2*ceil(d/2) clocks after S1.
- R5: An acknowledge, alone or together with a bus error, ends the cycle through S5, S6 and S7. On entering S7 all four strobes go high, `core_rdata` takes `bus_din`, `core_done` is high for exactly one clock, and `core_err` is 0.
- R6: A bus error without acknowledge runs through S5, S6, S7 and S8. When the cycle ends after S8, all four strobes go high and `core_done` and `core_err` are both high for one clock. `core_rdata` keeps its earlier value. `core_done` comes 8 + 2*ceil(d/2) clocks after S1.
- R7: While `bus_as_n` is low, the byte selects decide the data strobes. `bus_uds_n` is low exactly when `core_upper` was 1. `bus_lds_n` is low exactly when `core_lower` was 1. `bus_ds_n` is low when either was 1.
- R8: `bus_addr` takes the request address in S1 and holds it unchanged until the next cycle begins.
- R9: A `core_req` pulse seen while a cycle runs is held. Its cycle starts from idle after the current one ends. A further request that arrives while one is already held is dropped.
- R10: After reset, all five bus outputs are high, and `core_done`, `core_err` and `core_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus rate (one half-state per tick) |
| rst | input | 1 | Synchronous reset, active high |
| core_req | input | 1 | One-clock request to start a read |
| core_addr | input | ADDR_W | Read address, sampled with `core_req` |
| core_upper | input | 1 | Select upper byte lane |
| core_lower | input | 1 | Select lower byte lane |
| core_done | output | 1 | One-clock pulse when the read ends |
| core_err | output | 1 | High with `core_done` when the read ended in a bus error |
| core_rdata | output | DATA_W | Data captured by an acknowledged read |
| bus_start_n | output | 1 | Cycle-start marker, low during S1 |
| bus_addr | output | ADDR_W | Bus address |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_uds_n | output | 1 | Upper data strobe, active low |
| bus_lds_n | output | 1 | Lower data strobe, active low |
| bus_ds_n | output | 1 | Combined data strobe, active low |
| bus_din | input | DATA_W | Read data from the device |
| bus_ack_n | input | 1 | Data acknowledge, active low, asynchronous |
| bus_berr_n | input | 1 | Bus error, active low, asynchronous |

## Verification
The bench sweeps the acknowledge delay over odd and even values, because wait-pair rounding is easy to get wrong. A design that added single half-states, or that checked termination in the wrong state, would finish one clock early or late. Acknowledge and bus error are driven together to confirm the acknowledge path wins. A design that chose the error path would report an error and lose the data. A request is pushed in during a running cycle, followed by a second one. A design without the hold slot would lose the first, and one without the drop rule would run an extra cycle. Every byte-select combination is used, including neither lane, so a wrong strobe mapping appears on the pins at once.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

  // Half-clock states of one read transfer
  typedef enum logic [3:0] {
    ST_IDLE = 4'd0,
    ST_S1   = 4'd1,
    ST_S2   = 4'd2,
    ST_S3   = 4'd3,
    ST_S4   = 4'd4,
    ST_WA   = 4'd5,
    ST_WB   = 4'd6,
    ST_S5   = 4'd7,
    ST_S6   = 4'd8,
    ST_S7   = 4'd9,
    ST_E5   = 4'd10,
    ST_E6   = 4'd11,
    ST_E7   = 4'd12,
    ST_E8   = 4'd13
  } rd_state_t;

endpackage

// File: rtl/rdseq_sync.sv
module rdseq_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '0;
        else     chain[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '0;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/rdseq_req_slot.sv
module rdseq_req_slot #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_req,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_upper,
  input  logic              in_lower,
  input  logic              take,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_upper,
  output logic              out_lower
);

  logic              held_v;
  logic [ADDR_W-1:0] held_addr;
  logic              held_upper;
  logic              held_lower;

  // The held request is older, so it goes first
  always_comb begin
    out_valid = held_v | in_req;
    out_addr  = held_v ? held_addr  : in_addr;
    out_upper = held_v ? held_upper : in_upper;
    out_lower = held_v ? held_lower : in_lower;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_v     <= 1'b0;
      held_addr  <= '0;
      held_upper <= 1'b0;
      held_lower <= 1'b0;
    end else if (take) begin
      // Slot drains; a request arriving at the same edge refills it
      held_v <= held_v & in_req;
      if (held_v && in_req) begin
        held_addr  <= in_addr;
        held_upper <= in_upper;
        held_lower <= in_lower;
      end
    end else if (in_req && !held_v) begin
      held_v     <= 1'b1;
      held_addr  <= in_addr;
      held_upper <= in_upper;
      held_lower <= in_lower;
    end
  end

  AST_SLOT_KEEP: assert property (@(posedge clk) disable iff (rst)
    held_v && !take |=> held_v); // R9

endmodule

// File: rtl/rdseq_fsm.sv
module rdseq_fsm
  import rdseq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_upper,
  input  logic              req_lower,
  output logic              take,
  input  logic              term_ack,
  input  logic              term_err,
  input  logic [DATA_W-1:0] bus_din,
  output logic              bus_start_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_as_n,
  output logic              bus_uds_n,
  output logic              bus_lds_n,
  output logic              bus_ds_n,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata
);

  rd_state_t st;
  logic      sel_upper;
  logic      sel_lower;

  assign take = (st == ST_IDLE) && req_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      bus_start_n <= 1'b1;
      bus_addr    <= '0;
      bus_as_n    <= 1'b1;
      bus_uds_n   <= 1'b1;
      bus_lds_n   <= 1'b1;
      bus_ds_n    <= 1'b1;
      done        <= 1'b0;
      err         <= 1'b0;
      rdata       <= '0;
      sel_upper   <= 1'b0;
      sel_lower   <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (take) begin
            st          <= ST_S1;
            bus_start_n <= 1'b0;
            bus_addr    <= req_addr;
            sel_upper   <= req_upper;
            sel_lower   <= req_lower;
          end
        end
        ST_S1: begin
          st          <= ST_S2;
          bus_start_n <= 1'b1;
          bus_as_n    <= 1'b0;
          bus_uds_n   <= ~sel_upper;
          bus_lds_n   <= ~sel_lower;
          bus_ds_n    <= ~(sel_upper | sel_lower);
        end
        ST_S2: st <= ST_S3;
        ST_S3: st <= ST_S4;
        ST_S4, ST_WB: begin
          // Termination is checked only at whole-clock boundaries
          if (term_ack)      st <= ST_S5;
          else if (term_err) st <= ST_E5;
          else               st <= ST_WA;
        end
        ST_WA: st <= ST_WB;
        ST_S5: st <= ST_S6;
        ST_S6: begin
          st        <= ST_S7;
          bus_as_n  <= 1'b1;
          bus_uds_n <= 1'b1;
          bus_lds_n <= 1'b1;
          bus_ds_n  <= 1'b1;
          rdata     <= bus_din;
          done      <= 1'b1;
        end
        ST_S7: st <= ST_IDLE;
        ST_E5: st <= ST_E6;
        ST_E6: st <= ST_E7;
        ST_E7: st <= ST_E8;
        ST_E8: begin
          st        <= ST_IDLE;
          bus_as_n  <= 1'b1;
          bus_uds_n <= 1'b1;
          bus_lds_n <= 1'b1;
          bus_ds_n  <= 1'b1;
          done      <= 1'b1;
          err       <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    !bus_start_n |=> bus_start_n); // R1

  AST_STROBE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    !bus_start_n |=> !bus_as_n); // R2

  AST_WAIT_PAIR: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WA) |=> (st == ST_WB) && !bus_as_n); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R5

  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    done |-> bus_as_n && bus_uds_n && bus_lds_n && bus_ds_n); // R5

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    err |-> done); // R6

  AST_DS_COMBINED: assert property (@(posedge clk) disable iff (rst)
    !bus_as_n |-> (bus_ds_n == (bus_uds_n && bus_lds_n))); // R7

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    !bus_as_n |-> $stable(bus_addr)); // R8

endmodule

// File: rtl/async_rd_sequencer.sv
module async_rd_sequencer #(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core_req,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic              core_upper,
  input  logic              core_lower,
  output logic              core_done,
  output logic              core_err,
  output logic [DATA_W-1:0] core_rdata,
  output logic              bus_start_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_as_n,
  output logic              bus_uds_n,
  output logic              bus_lds_n,
  output logic              bus_ds_n,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              bus_ack_n,
  input  logic              bus_berr_n
);

  localparam int TERM_W = 2;

  logic [TERM_W-1:0] term_raw;
  logic [TERM_W-1:0] term_sync;
  logic              slot_valid;
  logic [ADDR_W-1:0] slot_addr;
  logic              slot_upper;
  logic              slot_lower;
  logic              take;

  // Bit 0: acknowledge, bit 1: bus error, both made active high
  assign term_raw = {~bus_berr_n, ~bus_ack_n};

  rdseq_sync #(
    .WIDTH  (TERM_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (term_raw),
    .q   (term_sync)
  );

  rdseq_req_slot #(
    .ADDR_W (ADDR_W)
  ) u_slot (
    .clk       (clk),
    .rst       (rst),
    .in_req    (core_req),
    .in_addr   (core_addr),
    .in_upper  (core_upper),
    .in_lower  (core_lower),
    .take      (take),
    .out_valid (slot_valid),
    .out_addr  (slot_addr),
    .out_upper (slot_upper),
    .out_lower (slot_lower)
  );

  rdseq_fsm #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (slot_valid),
    .req_addr    (slot_addr),
    .req_upper   (slot_upper),
    .req_lower   (slot_lower),
    .take        (take),
    .term_ack    (term_sync[0]),
    .term_err    (term_sync[1]),
    .bus_din     (bus_din),
    .bus_start_n (bus_start_n),
    .bus_addr    (bus_addr),
    .bus_as_n    (bus_as_n),
    .bus_uds_n   (bus_uds_n),
    .bus_lds_n   (bus_lds_n),
    .bus_ds_n    (bus_ds_n),
    .done        (core_done),
    .err         (core_err),
    .rdata       (core_rdata)
  );

endmodule

// File: tb/async_rd_sequencer_test.sv
module async_rd_sequencer_test;

  localparam int AW = 24;
  localparam int DW = 16;
  localparam logic [DW-1:0] SALT = 16'h5A3C;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          core_req = 1'b0;
  logic [AW-1:0] core_addr = '0;
  logic          core_upper = 1'b0;
  logic          core_lower = 1'b0;
  logic          core_done, core_err;
  logic [DW-1:0] core_rdata;
  logic          bus_start_n, bus_as_n, bus_uds_n, bus_lds_n, bus_ds_n;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_din = '0;
  logic          bus_ack_n = 1'b1;
  logic          bus_berr_n = 1'b1;

  int tests_run = 0;
  int tests_failed = 0;
  bit model_on = 0;

  always #2.5 clk = ~clk;

  async_rd_sequencer #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .core_req(core_req), .core_addr(core_addr),
    .core_upper(core_upper), .core_lower(core_lower), .core_done(core_done),
    .core_err(core_err), .core_rdata(core_rdata), .bus_start_n(bus_start_n),
    .bus_addr(bus_addr), .bus_as_n(bus_as_n), .bus_uds_n(bus_uds_n),
    .bus_lds_n(bus_lds_n), .bus_ds_n(bus_ds_n), .bus_din(bus_din),
    .bus_ack_n(bus_ack_n), .bus_berr_n(bus_berr_n));

  // Device responder: 0 acknowledge, 1 bus error, 2 both
  int resp_mode = 0;
  int resp_dly  = 0;
  int resp_cnt  = 0;
  always @(negedge clk) begin
    bus_din = bus_addr[DW-1:0] ^ SALT;
    if (bus_as_n !== 1'b0) begin
      bus_ack_n = 1'b1; bus_berr_n = 1'b1; resp_cnt = 0;
    end else begin
      if (resp_cnt >= resp_dly) begin
        bus_ack_n  = !(resp_mode == 0 || resp_mode == 2);
        bus_berr_n = !(resp_mode == 1 || resp_mode == 2);
      end
      resp_cnt++;
    end
  end

  // Behavioural reference: phase number per half-state, two-deep sync history
  int            ph;
  bit            pv, pu, pl, cu, cl, a1, a2, b1, b2, sa, sb;
  logic [AW-1:0] p_addr;
  logic          e_start, e_as, e_uds, e_lds, e_ds, e_done, e_err;
  logic [AW-1:0] e_addr;
  logic [DW-1:0] e_rdata;

  always @(posedge clk) begin
    if (rst) begin
      ph = 0; pv = 0; pu = 0; pl = 0; cu = 0; cl = 0; p_addr = '0;
      a1 = 0; a2 = 0; b1 = 0; b2 = 0;
      e_start = 1; e_as = 1; e_uds = 1; e_lds = 1; e_ds = 1;
      e_done = 0; e_err = 0; e_addr = '0; e_rdata = '0;
    end else begin
      sa = a2; sb = b2;
      a2 = a1; a1 = !bus_ack_n;
      b2 = b1; b1 = !bus_berr_n;
      e_done = 0; e_err = 0;
      if (ph == 0) begin
        if (pv || core_req) begin
          if (pv) begin
            e_addr = p_addr; cu = pu; cl = pl; pv = core_req;
            if (core_req) begin p_addr = core_addr; pu = core_upper; pl = core_lower; end
          end else begin
            e_addr = core_addr; cu = core_upper; cl = core_lower;
          end
          e_start = 0; ph = 1;
        end
      end else begin
        if (core_req && !pv) begin
          pv = 1; p_addr = core_addr; pu = core_upper; pl = core_lower;
        end
        case (ph)
          1: begin e_start = 1; e_as = 0; e_uds = !cu; e_lds = !cl; e_ds = !(cu || cl); ph = 2; end
          4, 6: ph = sa ? 7 : (sb ? 10 : 5);
          8: begin ph = 9; e_as = 1; e_uds = 1; e_lds = 1; e_ds = 1; e_rdata = bus_din; e_done = 1; end
          9: ph = 0;
          13: begin ph = 0; e_as = 1; e_uds = 1; e_lds = 1; e_ds = 1; e_done = 1; e_err = 1; end
          default: ph = ph + 1;
        endcase
      end
    end
  end

  task automatic fail1(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests_failed++;
    $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
  endtask

  // Per-clock comparison of every output against the reference
  always @(negedge clk) begin
    if (model_on && !rst) begin
      tests_run++;
      if (bus_start_n !== e_start) fail1("R1", "start_n", 32'(bus_start_n), 32'(e_start));
      if (bus_as_n    !== e_as)    fail1("R2", "as_n", 32'(bus_as_n), 32'(e_as));
      if (bus_uds_n   !== e_uds)   fail1("R7", "uds_n", 32'(bus_uds_n), 32'(e_uds));
      if (bus_lds_n   !== e_lds)   fail1("R7", "lds_n", 32'(bus_lds_n), 32'(e_lds));
      if (bus_ds_n    !== e_ds)    fail1("R7", "ds_n", 32'(bus_ds_n), 32'(e_ds));
      if (bus_addr    !== e_addr)  fail1("R8", "addr", 32'(bus_addr), 32'(e_addr));
      if (core_done   !== e_done)  fail1("R5", "done", 32'(core_done), 32'(e_done));
      if (core_err    !== e_err)   fail1("R6", "err", 32'(core_err), 32'(e_err));
      if (core_rdata  !== e_rdata) fail1("R5", "rdata", 32'(core_rdata), 32'(e_rdata));
    end
  end

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    tests_run++;
    if (!ok) fail1(req, what, act, exp);
  endtask

  task automatic pulse_req(logic [AW-1:0] a, bit u, bit l);
    core_addr = a; core_upper = u; core_lower = l; core_req = 1'b1;
    @(negedge clk);
    core_req = 1'b0;
  endtask

  // One read; measures clocks from S1 to done
  task automatic one_read(logic [AW-1:0] a, bit u, bit l, int mode, int dly,
                          int exp_len, string req);
    int n;
    logic [DW-1:0] prev;
    resp_mode = mode; resp_dly = dly;
    prev = core_rdata;
    @(negedge clk);
    pulse_req(a, u, l);
    check(bus_start_n === 1'b0, "R1", "start_n in S1", 32'(bus_start_n), 0);
    n = 0;
    while (core_done !== 1'b1 && n < 300) begin @(negedge clk); n++; end
    check(n == exp_len, req, "clocks S1 to done", 32'(n), 32'(exp_len));
    if (mode == 1) begin
      check(core_err === 1'b1, "R6", "err on bus error", 32'(core_err), 1);
      check(core_rdata === prev, "R6", "rdata kept", 32'(core_rdata), 32'(prev));
    end else begin
      check(core_err === 1'b0, "R5", "err on ack", 32'(core_err), 0);
      check(core_rdata === (a[DW-1:0] ^ SALT), "R5", "rdata", 32'(core_rdata),
            32'(a[DW-1:0] ^ SALT));
    end
    @(negedge clk);
    check(core_done === 1'b0, "R5", "done single pulse", 32'(core_done), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests_failed++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    int starts;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_on = 1;
    @(negedge clk);
    check(bus_start_n && bus_as_n && bus_uds_n && bus_lds_n && bus_ds_n, "R10",
          "strobes after reset", {bus_start_n, bus_as_n, bus_uds_n, bus_lds_n, bus_ds_n}, 32'h1f);
    check(!core_done && !core_err && core_rdata == 0, "R10", "core side after reset",
          {core_done, core_err, core_rdata}, 0);

    // R3: shortest cycle, acknowledge as soon as strobes appear
    one_read(24'h012345, 1, 1, 0, 0, 6, "R3");
    // R4: wait pairs round up
    for (int d = 1; d <= 6; d++)
      one_read(24'h100000 + 24'(d * 7), d[0], !d[0], 0, d, 6 + 2 * ((d + 1) / 2), "R4");
    // R7: no byte lane selected
    one_read(24'h00ABCD, 0, 0, 0, 2, 8, "R7");
    // R6: bus error alone
    for (int d = 0; d <= 3; d++)
      one_read(24'h200000 + 24'(d), 1, 0, 1, d, 8 + 2 * ((d + 1) / 2), "R6");
    // R5: both terminations, acknowledge wins
    one_read(24'h3F0F0F, 0, 1, 2, 1, 8, "R5");

    // R9: hold one request mid-cycle, drop the next
    resp_mode = 0; resp_dly = 3;
    @(negedge clk);
    starts = 0;
    fork
      begin
        for (int i = 0; i < 60; i++) begin
          @(negedge clk);
          if (bus_start_n === 1'b0) starts++;
        end
      end
      begin
        pulse_req(24'h4A0001, 1, 1);
        @(negedge clk);
        pulse_req(24'h4A0002, 1, 0);
        pulse_req(24'h4A0003, 0, 1);
      end
    join
    check(starts == 2, "R9", "cycles started", 32'(starts), 2);
    check(bus_addr === 24'h4A0002, "R9", "held address ran", 32'(bus_addr), 32'h4A0002);

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule